// File: doc/BRIEF.md
# Serial Cell Stream to FIFO Word Packer

This block sits on the receive side of a bit-serial cell link. It samples one data bit on every rising edge of the serial clock. It waits for a cell-announce bit and then reads the cell-type bit that follows it. Next it shifts in the 128-bit cell body, most significant bit first, and then the truncate bit and the parity bit.

The block emits the cell as a stream of 18-bit words on a FIFO write port. The cell body fills the lower 16 bits of eight successive words. The two upper bits act as side-band flags: on the first word they hold the announce and type bits, and on the trailer word they hold the truncate bit and a parity-error flag.

After each trailer the block reads the next two-bit delineator slot, and this slot decides where the packet ends:
- A data-cell delineator continues the current packet.
- A control-cell delineator starts a new packet straight away.
- An announce bit of zero closes the packet. The block then writes an all-zero word as an end marker.

When a packet is complete, the block raises a one-cycle interrupt. This happens either when the end marker is written or when a back-to-back control cell begins. If the FIFO reports full when a word is due, that word is dropped and a sticky overflow flag is set.

Top module: `latp_cell_deser`

## Requirements
- R1: After reset, fifo_wr, pkt_irq and overflow are all low, and no word is written while the line stays at 0.
- R2: A cell starts only on a 1 bit seen while hunting. The bit that follows is the cell type (1 = control, 0 = data). The first FIFO word of the cell carries 1 in bit 17 and the type in bit 16.
- R3: The 128 cell bits arrive MSB first and are written as eight words. Word k holds cell bits [127-16k : 112-16k] in bits 15:0. Words 2 to 8 carry 00 in bits 17:16.
- R4: The trailer word follows the eighth word. Bit 17 is the received truncate bit, bit 16 is the parity-error flag, and bits 15:0 are zero. The parity-error flag is 1 when the 128 cell bits, the truncate bit and the parity bit together hold an even number of ones.
- R5: If the first bit after a trailer is 0, the packet is closed: an all-zero word is written and pkt_irq pulses. The following bit is consumed as the rest of the delineator, and the block then hunts again.
- R6: A delineator of 1 then 0 after a trailer continues the packet with a data cell. No zero word is written between the cells and no interrupt is raised.
- R7: A delineator of 1 then 1 after a trailer starts a new packet back to back. No zero word is written, and pkt_irq pulses once for the finished packet.
- R8: pkt_irq is never high on two consecutive cycles, and it is raised only after at least one trailer of the current packet.
- R9: When fifo_full is high as a word is due, that word is not written and overflow goes high. Overflow stays high until reset, and later words are written normally once fifo_full is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata | input | 1 | Serial line data, idle low |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| fifo_wr | output | 1 | Write strobe for fifo_wdata |
| fifo_wdata | output | 18 | Word to write: two flag bits over 16 data bits |
| pkt_irq | output | 1 | One-cycle packet-ready pulse |
| overflow | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
The assertions assume that fifo_full is a registered signal that stays steady through each bit period, and that sdata is a clean synchronous line that idles at 0 between packets. They also assume that every cell is sent whole, with its delineator, 128 bits, truncate bit and parity bit; a cell cut short would leave the counter mid-cell. The stimulus changes sdata and fifo_full only on falling clock edges and always sends complete cells. After every closed packet it holds the line low for a few bit times, so the hunt state is entered cleanly before the next announce bit.

// File: rtl/latp_cell_deser.sv
module latp_cell_deser #(
  parameter int WORD_W     = 16,
  parameter int CELL_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W+1:0] fifo_wdata,
  output logic              pkt_irq,
  output logic              overflow
);
  localparam int CELL_BITS = WORD_W * CELL_WORDS;
  localparam int CNT_W     = $clog2(CELL_BITS);
  localparam int SUB_W     = $clog2(WORD_W);
  localparam int FW        = WORD_W + 2;

  typedef enum logic [2:0] {
    S_HUNT, S_TYPE, S_CELL, S_TRUNC, S_PAR, S_ANN, S_DTYP, S_SKIP
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] sh;
  logic             ctype, trunc, par, pkt_open;

  logic             want, irq_n;
  logic [FW-1:0]    wdata_n;

  wire word_end  = (cnt[SUB_W-1:0] == '1);
  wire first_wd  = (cnt[CNT_W-1:SUB_W] == '0);
  wire cell_end  = (cnt == CNT_W'(CELL_BITS - 1));

  always_comb begin
    want    = 1'b0;
    irq_n   = 1'b0;
    wdata_n = '0;
    case (st)
      S_CELL: if (word_end) begin
        want    = 1'b1;
        wdata_n = {(first_wd ? {1'b1, ctype} : 2'b00), sh[WORD_W-2:0], sdata};
      end
      S_PAR: begin
        want    = 1'b1;
        wdata_n = {trunc, ~(par ^ sdata), {WORD_W{1'b0}}};
      end
      S_ANN: if (!sdata) begin
        want  = 1'b1;
        irq_n = 1'b1;
      end
      S_DTYP: irq_n = sdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HUNT;
      cnt        <= '0;
      sh         <= '0;
      ctype      <= 1'b0;
      trunc      <= 1'b0;
      par        <= 1'b0;
      pkt_open   <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      pkt_irq    <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      fifo_wr  <= want & ~fifo_full;
      overflow <= overflow | (want & fifo_full);
      pkt_irq  <= irq_n;
      if (want) fifo_wdata <= wdata_n;
      case (st)
        S_HUNT: if (sdata) st <= S_TYPE;
        S_TYPE, S_DTYP: begin
          ctype <= sdata;
          cnt   <= '0;
          par   <= 1'b0;
          st    <= S_CELL;
          if (st == S_DTYP && sdata) pkt_open <= 1'b0;
        end
        S_CELL: begin
          sh  <= {sh[WORD_W-2:0], sdata};
          par <= par ^ sdata;
          cnt <= cnt + 1'b1;
          if (cell_end) st <= S_TRUNC;
        end
        S_TRUNC: begin
          trunc <= sdata;
          par   <= par ^ sdata;
          st    <= S_PAR;
        end
        S_PAR: begin
          pkt_open <= 1'b1;
          st       <= S_ANN;
        end
        S_ANN: begin
          if (sdata) st <= S_DTYP;
          else begin
            pkt_open <= 1'b0;
            st       <= S_SKIP;
          end
        end
        S_SKIP: st <= S_HUNT;
        default: st <= S_HUNT;
      endcase
    end
  end

  // R9
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_irq |=> !pkt_irq);

  // R8
  irq_after_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_irq |-> $past(pkt_open));

  // R3
  cell_counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CELL && !cell_end) |=> (st == S_CELL && cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/latp_cell_deser_tb_top.sv
`timescale 1ns/1ps
module latp_cell_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_wr;
  logic [17:0] fifo_wdata;
  logic        pkt_irq;
  logic        overflow;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  int exp_irq = 0;
  int cycles = 0;
  logic irq_prev = 1'b0;
  logic [17:0] exp_q[$];
  int          tag_q[$];

  always #2.5 clk = ~clk;

  latp_cell_deser dut_i (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .pkt_irq(pkt_irq), .overflow(overflow)
  );

  // fields: [11] ctype, [10] truncate, [9] corrupt parity, [8] close after, [7:0] seed
  localparam logic [11:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h22},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h33},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h44},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h55},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h66},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h77},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h88},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h99},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}
  };

  function automatic logic [15:0] payload(input logic [7:0] s, input int k);
    payload = {s ^ 8'(k * 29), 8'(~s + 8'(k * 37))};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && pkt_irq) irq_cnt++;
    // R8: one-cycle pulse
    if (rst_n && pkt_irq && irq_prev) check(1'b0, "R8", 32'd2, 32'd1);
    irq_prev = pkt_irq;
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R9 unexpected write", {14'h0, fifo_wdata}, 32'h0);
      else begin
        automatic logic [17:0] e = exp_q.pop_front();
        automatic int t = tag_q.pop_front();
        check(fifo_wdata == e, $sformatf("R%0d word", t), {14'h0, fifo_wdata}, {14'h0, e});
      end
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic bit_out(input logic b);
    @(negedge clk);
    sdata = b;
  endtask

  task automatic expect_word(input logic [17:0] w, input int t, input bit en);
    if (en) begin
      exp_q.push_back(w);
      tag_q.push_back(t);
    end
  endtask

  task automatic send_cell(input logic ct, input logic tr, input logic bad,
                           input logic [7:0] seed, input bit en);
    logic p = 1'b0;
    bit_out(1'b1);
    bit_out(ct);
    for (int k = 0; k < 8; k++) begin
      automatic logic [15:0] w = payload(seed, k);
      // R2 first word header, R3 payload words
      expect_word({(k == 0) ? {1'b1, ct} : 2'b00, w}, (k == 0) ? 2 : 3, en);
      for (int b = 15; b >= 0; b--) begin
        bit_out(w[b]);
        p ^= w[b];
      end
    end
    bit_out(tr);
    p ^= tr;
    // R4 trailer: truncate in bit 17, parity error in bit 16
    expect_word({tr, bad, 16'h0}, 4, en);
    bit_out(~p ^ bad);
  endtask

  task automatic close_pkt(input bit en);
    expect_word(18'h0, 5, en);  // R5 zero word
    exp_irq++;
    bit_out(1'b0);
    bit_out(1'b0);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
  endtask

  initial begin
    bit open;
    open = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fifo_wr == 1'b0, "R1 fifo_wr", fifo_wr, 0);
    check(pkt_irq == 1'b0, "R1 pkt_irq", pkt_irq, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    rst_n = 1'b1;
    // R1/R2: idle line writes nothing
    for (int i = 0; i < 40; i++) bit_out(1'b0);
    check(exp_q.size() == 0 && irq_cnt == 0, "R2 idle", irq_cnt, 0);

    for (int v = 0; v < 10; v++) begin
      automatic logic [11:0] e = VEC[v];
      if (open && e[11]) exp_irq++;  // R7 back-to-back
      send_cell(e[11], e[10], e[9], e[7:0], 1'b1);
      open = 1'b1;
      if (e[8]) begin
        close_pkt(1'b1);
        open = 1'b0;
        check(irq_cnt == exp_irq, "R5/R6/R7 irq count", irq_cnt, exp_irq);
        check(exp_q.size() == 0, "R3/R6 words drained", exp_q.size(), 0);
      end
    end

    // R9: full FIFO drops words, flag sticks
    fifo_full = 1'b1;
    send_cell(1'b1, 1'b0, 1'b0, 8'h3C, 1'b0);
    close_pkt(1'b0);
    check(overflow == 1'b1, "R9 overflow set", overflow, 1);
    check(irq_cnt == exp_irq, "R9 irq count", irq_cnt, exp_irq);
    fifo_full = 1'b0;
    send_cell(1'b1, 1'b1, 1'b1, 8'hC3, 1'b1);
    close_pkt(1'b1);
    check(exp_q.size() == 0, "R9 writes resume", exp_q.size(), 0);
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    // R1: reset clears overflow
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(overflow == 1'b0 && fifo_wr == 1'b0, "R1 after reset", overflow, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0, "R3 final queue", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule